// File: doc/BRIEF.md
# Multiprocessor Interrupt Router

This block collects a small set of external interrupt lines and software-raised interprocessor interrupts and hands them to a few processors. Each external line has its own detector. A per-line setting picks edge or level detection and the active polarity. Each line also has a mask, a priority and a vector, plus a destination bitmask that names the processors allowed to take it. Each interprocessor interrupt has its own vector, priority and mask. It is raised on a set of processors by writing a processor bitmask to its dispatch register.

Each processor has a task priority, an acknowledge register and an end-of-service register. The router drives a processor's request pin when the best eligible interrupt for that processor has a priority strictly above both its task priority and the priority of whatever it is already serving. Reading the acknowledge register returns that interrupt's vector and moves the interrupt into the processor's in-service set. If nothing is deliverable, the read returns the global spurious vector. A write to the end-of-service register retires the highest-priority entry in that set.

A per-entry activity bit shows when the vector and priority of an entry can be changed safely. A global configuration register holds a self-clearing reset bit. All access goes through a single 32-bit register port with no handshake. A write takes effect at the clock edge where `reg_wr` is sampled high. Read data appears on `reg_rdata` in the cycle after the edge that samples `reg_rd`.

Top module: `intr_hub`

## Requirements
- R1: After reset every request pin is low and every entry is masked. A source entry reads 0x80010000. The spurious vector reads 0xFF. The feature register at 0x01 reads version in [7:0] (value 2), source count minus one in [15:8] and processor count minus one in [23:16].
- R2: Bit 31 of an entry register is its mask. A masked entry never raises a request. Clearing the mask lets an already-active entry raise a request.
- R3: Bit 17 of a source entry selects level (1) or edge (0) detection. Bit 16 selects active-high or rising (1), or active-low or falling (0). An edge stays latched until it is acknowledged. A level request follows the line one cycle after the line changes.
- R4: The destination register at 0x11+2*s (one bit per processor) decides which processors may see source s. The entry register of source s is at 0x10+2*s.
- R5: An entry is delivered only if its priority (bits 11:8) is strictly greater than the processor's task priority at 0x30+4*c. Among eligible entries the highest priority wins, and on a tie the lowest index wins. Interprocessor entries follow the sources in index order.
- R6: A read of 0x31+4*c returns the delivered vector (bits 7:0) and clears the latched edge. With nothing deliverable it returns the spurious vector at 0x02.
- R7: While an entry is in service on a processor, only an entry of strictly higher priority is delivered to that processor. A write to 0x32+4*c retires the highest-priority in-service entry.
- R8: Bit 30 of an entry reads 1 while the entry is pending or in service, and 0 otherwise.
- R9: Interprocessor entry j has its entry register at 0x20+j. A write of a processor bitmask to 0x28+j raises entry j on each named processor. Each processor acknowledges and retires its own copy.
- R10: Writing bit 0 of 0x00 clears all pending and in-service state and sets every mask one cycle later, and the bit then reads 0 again. Bit 1 is stored and read back.
- R11: If a new edge arrives in the same cycle as the acknowledge of that source, the new edge remains pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | External interrupt lines |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (acknowledge reads have side effects) |
| reg_addr | input | 8 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read |
| cpu_irq | output | NUM_CPU | Interrupt request, one per processor |

## Verification
Two things can happen on one source in the same cycle: an acknowledge read can clear its latched edge while the detector sees a fresh edge on the line. The bench provokes this by pulsing the line low and holding it pending, then raising it again in the very cycle the acknowledge read is issued. It judges the result at the ports. After the end-of-service write the request must come back and a second acknowledge must return the same vector. A design that let the clear win would leave the request low.

// File: rtl/intr_hub_pkg.sv
package intr_hub_pkg;
  localparam int PRIO_W = 4;
  localparam int VEC_W  = 8;

  typedef struct packed {
    logic              mask;
    logic              sense;
    logic              pol;
    logic [PRIO_W-1:0] prio;
    logic [VEC_W-1:0]  vec;
  } entry_t;

  function automatic logic [31:0] entry_pack(entry_t e, logic act);
    logic [31:0] w;
    w = '0;
    w[31] = e.mask;
    w[30] = act;
    w[17] = e.sense;
    w[16] = e.pol;
    w[8 +: PRIO_W] = e.prio;
    w[VEC_W-1:0] = e.vec;
    return w;
  endfunction

  function automatic entry_t entry_unpack(logic [31:0] w);
    entry_t e;
    e.mask  = w[31];
    e.sense = w[17];
    e.pol   = w[16];
    e.prio  = w[8 +: PRIO_W];
    e.vec   = w[VEC_W-1:0];
    return e;
  endfunction
endpackage

// File: rtl/intr_prio_pick.sv
module intr_prio_pick #(
  parameter int N  = 6,
  parameter int PW = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] pri,
  output logic            valid,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   best
);
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    best  = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && (!valid || pri[i*PW +: PW] > best)) begin
        valid = 1'b1;
        idx   = IW'(i);
        best  = pri[i*PW +: PW];
      end
    end
  end
endmodule

// File: rtl/intr_src_sense.sv
module intr_src_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic rearm,
  input  logic line,
  input  logic pol,
  input  logic sense,
  input  logic ack_clr,
  output logic req
);
  logic active, act_q, pend_q;

  assign active = pol ? line : ~line;
  assign req    = sense ? act_q : pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      act_q <= active;
      if (rearm)                             pend_q <= 1'b0;
      else if (!sense && active && !act_q)   pend_q <= 1'b1;
      else if (ack_clr)                      pend_q <= 1'b0;
    end
  end

  AST_NEW_EDGE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (!rearm && !sense && active && !act_q && ack_clr) |=> pend_q); // R11
endmodule

// File: rtl/intr_cpu_ctx.sv
module intr_cpu_ctx #(
  parameter int N  = 6,
  parameter int PW = 4,
  parameter int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_all,
  input  logic [N-1:0]  cand,
  input  logic [N*PW-1:0] pri,
  input  logic [PW-1:0] task_pri,
  input  logic          ack,
  input  logic          eoi,
  output logic          irq,
  output logic          ack_fire,
  output logic [IW-1:0] ack_idx,
  output logic [N-1:0]  isr
);
  logic          c_valid, s_valid;
  logic [IW-1:0] c_idx, s_idx;
  logic [PW-1:0] c_pri, s_pri, thr;

  intr_prio_pick #(.N(N), .PW(PW), .IW(IW)) u_cand (
    .req(cand), .pri(pri), .valid(c_valid), .idx(c_idx), .best(c_pri));
  intr_prio_pick #(.N(N), .PW(PW), .IW(IW)) u_serv (
    .req(isr), .pri(pri), .valid(s_valid), .idx(s_idx), .best(s_pri));

  assign thr      = (s_valid && s_pri > task_pri) ? s_pri : task_pri;
  assign irq      = c_valid && (c_pri > thr);
  assign ack_fire = ack && irq;
  assign ack_idx  = c_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  isr <= '0;
    else if (clr_all)            isr <= '0;
    else if (ack_fire)           isr[c_idx] <= 1'b1;
    else if (eoi && s_valid)     isr[s_idx] <= 1'b0;
  end

  AST_ACK_ENTERS_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !clr_all) |=> isr[$past(ack_idx)]); // R6
  AST_EOI_RETIRES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !ack && !clr_all && (isr != '0)) |=> ($countones(isr) == $countones($past(isr)) - 1)); // R7
endmodule

// File: rtl/intr_hub.sv
module intr_hub
  import intr_hub_pkg::*;
#(
  parameter int NUM_SRC  = 4,
  parameter int NUM_CPU  = 2,
  parameter int NUM_IPI  = 2,
  parameter int VERSION  = 2,
  parameter logic [7:0] SPUR_RST = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_in,
  input  logic               reg_wr,
  input  logic               reg_rd,
  input  logic [7:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic [NUM_CPU-1:0] cpu_irq
);
  localparam int N_ITEM = NUM_SRC + NUM_IPI;
  localparam int IW     = (N_ITEM > 1) ? $clog2(N_ITEM) : 1;

  entry_t             src_e [NUM_SRC];
  logic [NUM_CPU-1:0] src_dst [NUM_SRC];
  entry_t             ipi_e [NUM_IPI];
  logic [NUM_CPU-1:0] ipi_pend [NUM_IPI];
  logic [PRIO_W-1:0]  task_q [NUM_CPU];
  logic [7:0]         spur_q;
  logic               cfg_rst_q, cfg_keep_q;

  logic [3:0] grp, lo;
  logic [2:0] src_sel, ipi_sel;
  logic [1:0] cpu_sel;
  assign grp     = reg_addr[7:4];
  assign lo      = reg_addr[3:0];
  assign src_sel = reg_addr[3:1];
  assign ipi_sel = reg_addr[2:0];
  assign cpu_sel = reg_addr[3:2];

  logic [NUM_SRC-1:0]  src_req, src_clr, src_vp_wr, src_act;
  logic [NUM_IPI-1:0]  ipi_act;
  logic [N_ITEM-1:0]   serv_any;
  logic [N_ITEM*PRIO_W-1:0] pri_flat;
  logic [VEC_W-1:0]    item_vec [N_ITEM];
  logic [N_ITEM-1:0]   cand [NUM_CPU];
  logic [N_ITEM-1:0]   isr [NUM_CPU];
  logic [IW-1:0]       ack_idx [NUM_CPU];
  logic [NUM_CPU-1:0]  ack_fire, ack_rd, eoi_wr;
  logic [31:0]         rd_mux;

  always_comb begin
    for (int i = 0; i < NUM_SRC; i++) begin
      pri_flat[i*PRIO_W +: PRIO_W] = src_e[i].prio;
      item_vec[i] = src_e[i].vec;
      src_vp_wr[i] = reg_wr && grp == 4'h1 && !reg_addr[0] && int'(src_sel) == i;
    end
    for (int j = 0; j < NUM_IPI; j++) begin
      pri_flat[(NUM_SRC+j)*PRIO_W +: PRIO_W] = ipi_e[j].prio;
      item_vec[NUM_SRC+j] = ipi_e[j].vec;
    end
    serv_any = '0;
    for (int c = 0; c < NUM_CPU; c++) serv_any = serv_any | isr[c];
    src_clr = '0;
    for (int c = 0; c < NUM_CPU; c++)
      for (int i = 0; i < NUM_SRC; i++)
        if (ack_fire[c] && int'(ack_idx[c]) == i) src_clr[i] = 1'b1;
    for (int i = 0; i < NUM_SRC; i++) src_act[i] = src_req[i] | serv_any[i];
    for (int j = 0; j < NUM_IPI; j++) ipi_act[j] = (|ipi_pend[j]) | serv_any[NUM_SRC+j];
  end

  genvar gs, gc;
  generate
    for (gs = 0; gs < NUM_SRC; gs++) begin : g_src
      intr_src_sense u_sense (
        .clk(clk), .rst_n(rst_n), .rearm(src_vp_wr[gs] | cfg_rst_q),
        .line(irq_in[gs]), .pol(src_e[gs].pol), .sense(src_e[gs].sense),
        .ack_clr(src_clr[gs]), .req(src_req[gs]));
    end
    for (gc = 0; gc < NUM_CPU; gc++) begin : g_cpu
      always_comb begin
        for (int i = 0; i < NUM_SRC; i++)
          cand[gc][i] = src_req[i] & ~src_e[i].mask & src_dst[i][gc] & ~serv_any[i];
        for (int j = 0; j < NUM_IPI; j++)
          cand[gc][NUM_SRC+j] = ipi_pend[j][gc] & ~ipi_e[j].mask;
      end
      assign ack_rd[gc] = reg_rd && grp == 4'h3 && int'(cpu_sel) == gc && reg_addr[1:0] == 2'd1;
      assign eoi_wr[gc] = reg_wr && grp == 4'h3 && int'(cpu_sel) == gc && reg_addr[1:0] == 2'd2;
      intr_cpu_ctx #(.N(N_ITEM), .PW(PRIO_W), .IW(IW)) u_ctx (
        .clk(clk), .rst_n(rst_n), .clr_all(cfg_rst_q), .cand(cand[gc]),
        .pri(pri_flat), .task_pri(task_q[gc]), .ack(ack_rd[gc]), .eoi(eoi_wr[gc]),
        .irq(cpu_irq[gc]), .ack_fire(ack_fire[gc]), .ack_idx(ack_idx[gc]), .isr(isr[gc]));

      AST_EMPTY_ACK_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd[gc] && !reg_wr && !cpu_irq[gc]) |=> (reg_rdata == {24'b0, $past(spur_q)})); // R6
    end
  endgenerate

  always_comb begin
    rd_mux = '0;
    case (grp)
      4'h0: case (lo)
        4'h0: rd_mux = {30'b0, cfg_keep_q, cfg_rst_q};
        4'h1: rd_mux = {8'h00, 8'(NUM_CPU-1), 8'(NUM_SRC-1), 8'(VERSION)};
        4'h2: rd_mux = {24'b0, spur_q};
        default: rd_mux = '0;
      endcase
      4'h1: for (int i = 0; i < NUM_SRC; i++)
        if (int'(src_sel) == i)
          rd_mux = reg_addr[0] ? 32'(src_dst[i]) : entry_pack(src_e[i], src_act[i]);
      4'h2: for (int j = 0; j < NUM_IPI; j++)
        if (!reg_addr[3] && int'(ipi_sel) == j) rd_mux = entry_pack(ipi_e[j], ipi_act[j]);
      4'h3: for (int c = 0; c < NUM_CPU; c++)
        if (int'(cpu_sel) == c) begin
          if (reg_addr[1:0] == 2'd0) rd_mux = 32'(task_q[c]);
          else if (reg_addr[1:0] == 2'd1)
            rd_mux = cpu_irq[c] ? 32'(item_vec[ack_idx[c]]) : {24'b0, spur_q};
        end
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SRC; i++) begin
        src_e[i]   <= '{mask: 1'b1, sense: 1'b0, pol: 1'b1, prio: '0, vec: '0};
        src_dst[i] <= '0;
      end
      for (int j = 0; j < NUM_IPI; j++) begin
        ipi_e[j]    <= '{mask: 1'b1, sense: 1'b0, pol: 1'b0, prio: '0, vec: '0};
        ipi_pend[j] <= '0;
      end
      for (int c = 0; c < NUM_CPU; c++) task_q[c] <= '0;
      spur_q     <= SPUR_RST;
      cfg_rst_q  <= 1'b0;
      cfg_keep_q <= 1'b0;
      reg_rdata  <= '0;
    end else begin
      for (int j = 0; j < NUM_IPI; j++)
        for (int c = 0; c < NUM_CPU; c++)
          if (ack_fire[c] && int'(ack_idx[c]) == NUM_SRC + j) ipi_pend[j][c] <= 1'b0;
      if (cfg_rst_q) begin
        cfg_rst_q <= 1'b0;
        for (int i = 0; i < NUM_SRC; i++) src_e[i].mask <= 1'b1;
        for (int j = 0; j < NUM_IPI; j++) begin
          ipi_e[j].mask <= 1'b1;
          ipi_pend[j]   <= '0;
        end
      end
      if (reg_wr) begin
        case (grp)
          4'h0: begin
            if (lo == 4'h0) begin
              cfg_rst_q  <= reg_wdata[0];
              cfg_keep_q <= reg_wdata[1];
            end
            if (lo == 4'h2) spur_q <= reg_wdata[7:0];
          end
          4'h1: for (int i = 0; i < NUM_SRC; i++)
            if (int'(src_sel) == i) begin
              if (reg_addr[0]) src_dst[i] <= reg_wdata[NUM_CPU-1:0];
              else             src_e[i]   <= entry_unpack(reg_wdata);
            end
          4'h2: for (int j = 0; j < NUM_IPI; j++)
            if (int'(ipi_sel) == j) begin
              if (reg_addr[3]) ipi_pend[j] <= ipi_pend[j] | reg_wdata[NUM_CPU-1:0];
              else begin
                ipi_e[j]       <= entry_unpack(reg_wdata);
                ipi_e[j].sense <= 1'b0;
                ipi_e[j].pol   <= 1'b0;
              end
            end
          4'h3: for (int c = 0; c < NUM_CPU; c++)
            if (int'(cpu_sel) == c && reg_addr[1:0] == 2'd0) task_q[c] <= reg_wdata[PRIO_W-1:0];
          default: ;
        endcase
      end
      if (reg_rd) reg_rdata <= rd_mux;
    end
  end

  AST_RESET_SETS_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rst_q && !reg_wr) |=> (src_e[0].mask && ipi_e[0].mask && ipi_pend[0] == '0)); // R10
  AST_RESET_SELF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rst_q && !(reg_wr && reg_addr == 8'h00)) |=> !cfg_rst_q); // R10
endmodule

// File: tb/intr_hub_bench.sv
module intr_hub_bench;
  localparam int NS = 4;
  localparam int NC = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] irq_in = 4'b0010;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic [NC-1:0] cpu_irq;

  int checks = 0, fails = 0;
  logic rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  intr_hub u_intr_hub (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cpu_irq(cpu_irq));

  // Monitor: compares read data against the scoreboard queue
  always @(posedge clk) rd_d <= reg_rd;
  always @(negedge clk) begin
    if (rd_d && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      checks++;
      if (reg_rdata !== e) begin
        fails++;
        $display("FAIL %s rdata actual=%h expected=%h", t, reg_rdata, e);
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    reg_rd = 1'b1; reg_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic chk_irq(input logic [NC-1:0] e, input string t);
    checks++;
    if (cpu_irq !== e) begin
      fails++;
      $display("FAIL %s cpu_irq actual=%b expected=%b", t, cpu_irq, e);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk_irq(2'b00, "R1");
    rd(8'h01, 32'h0001_0302, "R1 feature");
    rd(8'h10, 32'h8001_0000, "R1 entry");
    rd(8'h02, 32'h0000_00FF, "R1 spurious");

    // R3 edge, R4 destination, R6 ack, R8 activity
    wr(8'h10, 32'h0001_0540);
    wr(8'h11, 32'h1);
    irq_in[0] = 1'b1; tick();
    chk_irq(2'b01, "R4");
    rd(8'h10, 32'h4001_0540, "R8 pending");
    rd(8'h31, 32'h40, "R6 vector");
    chk_irq(2'b00, "R7");
    rd(8'h31, 32'hFF, "R6 spurious");
    wr(8'h32, 32'h0);
    chk_irq(2'b00, "R3 edge consumed");
    rd(8'h10, 32'h0001_0540, "R8 idle");

    // R3 level active-low to processor 1
    wr(8'h12, 32'h0002_0341);
    wr(8'h13, 32'h2);
    chk_irq(2'b00, "R3 idle level");
    irq_in[1] = 1'b0; tick();
    chk_irq(2'b10, "R3 level");
    rd(8'h35, 32'h41, "R6 cpu1");
    chk_irq(2'b00, "R7 served");
    wr(8'h36, 32'h0);
    chk_irq(2'b10, "R3 level persists");
    irq_in[1] = 1'b1; tick();
    chk_irq(2'b00, "R3 level released");

    // R2 mask
    wr(8'h12, 32'h8002_0341);
    irq_in[1] = 1'b0; tick();
    chk_irq(2'b00, "R2 masked");
    wr(8'h12, 32'h0002_0341);
    chk_irq(2'b10, "R2 unmasked");
    irq_in[1] = 1'b1; tick();

    // R5 priority threshold and tie
    wr(8'h14, 32'h0001_0542); wr(8'h15, 32'h1);
    wr(8'h16, 32'h0001_0543); wr(8'h17, 32'h1);
    wr(8'h30, 32'h5);
    irq_in[3:2] = 2'b11; tick();
    irq_in[3:2] = 2'b00; tick();
    chk_irq(2'b00, "R5 equal task");
    wr(8'h30, 32'h4);
    chk_irq(2'b01, "R5 above task");
    rd(8'h31, 32'h42, "R5 tie lowest index");
    chk_irq(2'b00, "R7 equal no preempt");
    wr(8'h32, 32'h0);
    chk_irq(2'b01, "R7 after eoi");
    rd(8'h31, 32'h43, "R5 second");
    wr(8'h32, 32'h0);
    wr(8'h30, 32'h0);
    chk_irq(2'b00, "R7 drained");

    // R7 preemption and retire order
    wr(8'h14, 32'h0001_0942);
    irq_in[0] = 1'b0; tick();
    irq_in[0] = 1'b1; tick();
    chk_irq(2'b01, "R7 low");
    rd(8'h31, 32'h40, "R7 low vec");
    irq_in[2] = 1'b1; tick();
    irq_in[2] = 1'b0; tick();
    chk_irq(2'b01, "R7 preempt");
    rd(8'h31, 32'h42, "R7 high vec");
    wr(8'h32, 32'h0);
    rd(8'h14, 32'h0001_0942, "R7 high retired");
    rd(8'h10, 32'h4001_0540, "R7 low still served");
    wr(8'h32, 32'h0);
    rd(8'h10, 32'h0001_0540, "R8 low retired");

    // R9 interprocessor dispatch
    wr(8'h20, 32'h0000_0750);
    wr(8'h28, 32'h3);
    chk_irq(2'b11, "R9 both");
    rd(8'h31, 32'h50, "R9 cpu0");
    chk_irq(2'b10, "R9 cpu1 left");
    rd(8'h35, 32'h50, "R9 cpu1");
    rd(8'h20, 32'h4000_0750, "R9 activity");
    wr(8'h32, 32'h0);
    wr(8'h36, 32'h0);
    rd(8'h20, 32'h0000_0750, "R9 idle");
    chk_irq(2'b00, "R9 done");

    // R11 new edge in the acknowledge cycle
    irq_in[0] = 1'b0; tick();
    irq_in[0] = 1'b1; tick();
    chk_irq(2'b01, "R11 setup");
    irq_in[0] = 1'b0; tick();
    chk_irq(2'b01, "R3 edge held");
    irq_in[0] = 1'b1;
    rd(8'h31, 32'h40, "R11 ack");
    chk_irq(2'b00, "R11 served");
    wr(8'h32, 32'h0);
    chk_irq(2'b01, "R11 re-pending");
    rd(8'h31, 32'h40, "R11 second ack");
    wr(8'h32, 32'h0);
    chk_irq(2'b00, "R11 done");

    // R10 configuration reset
    irq_in[2] = 1'b1; tick();
    irq_in[2] = 1'b0; tick();
    chk_irq(2'b01, "R10 setup");
    wr(8'h00, 32'h3);
    rd(8'h00, 32'h3, "R10 set");
    rd(8'h00, 32'h2, "R10 self clear");
    chk_irq(2'b00, "R10 cleared");
    rd(8'h14, 32'h8001_0942, "R10 masked");
    tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule